// File: doc/BRIEF.md
# Long-Press Reset Pulse Timer

This block turns a deliberate two-button long press into a single system reset pulse. It watches two active-low button inputs. A hold timer runs only while both buttons are down together. When either button comes up early, the timer clears without any visible effect. Once the combined hold lasts for the chosen time, the block drives a reset pulse of fixed length on two outputs of opposite polarity. It then waits for the buttons to be released before it arms again.

The hold time comes from a 2-bit select that is wired to a constant level. The select is treated as static configuration. All time intervals are counted from a free-running clock whose frequency is a parameter. A prescaler divides the clock down to a 50 ms tick, and a main counter counts those ticks. With the default parameters the prescaler and the main counter together are 21 bits wide. Each button passes through a two-flop synchroniser before it reaches the control state machine.

Top module: `lpr_timer`

## Requirements
- R1: Each button input is synchronised through two flops. When both buttons go low before rising clock edge P0, a pulse with hold length N clock cycles first appears at the outputs after edge P0+N+1. This is N+2 edges after the press.
- R2: The hold timer advances only while both synchronised buttons are low. A single button held low for any length of time never produces a pulse.
- R3: If either button is seen high before the hold time completes, the timer clears to zero and the outputs stay idle. A later press must then be held for the full hold time, counted from that later press.
- R4: The hold time is a number of 50 ms ticks, and one tick is CLK_HZ/20 clock cycles. The number of ticks depends on hold_sel as follows: code 0 gives 60 ticks (3.00 s), 1 gives 75 ticks (3.75 s), 2 gives 90 ticks (4.50 s) and 3 gives 120 ticks (6.00 s). hold_sel[1] is the more significant bit.
- R5: During a pulse, rst_n_o is low and rst_o is high. Both stay asserted for exactly PULSE_TICKS ticks, which is 8 ticks (400 ms) by default. They then return to idle.
- R6: A press produces exactly one pulse, however long it is held. A new pulse needs at least one button to be seen high and then both to be held low again for the full hold time.
- R7: Synchronous reset rst forces idle: rst_n_o high, rst_o low, counters cleared and the button synchronisers read as released. Counting then starts over.
- R8: Button activity during a pulse has no effect on the pulse length.
- R9: rst_o is always the complement of rst_n_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock of CLK_HZ |
| rst | input | 1 | Synchronous reset, active high |
| btn_a_n | input | 1 | First button, active low, asynchronous |
| btn_b_n | input | 1 | Second button, active low, asynchronous |
| hold_sel | input | 2 | Static hold-time select (see R4) |
| rst_n_o | output | 1 | Reset pulse, active low |
| rst_o | output | 1 | Reset pulse, active high |

## Verification
The bench aims at the edges of the hold window. It uses a press released one tick short of the hold time, and a one-cycle release glitch in the middle of a hold. A design that fails to clear would fire on the next press early, and a design that misses the glitch would fire with no full hold. The bench holds the buttons long after a pulse, and a design without the release latch would then emit a train of pulses. It also drops the buttons during a pulse, which catches a design that ends the pulse early. Finally, each select code is measured against its exact cycle latency, so an off-by-one in the tick compare or the synchroniser depth is visible as a wrong latency.

// File: rtl/lpr_pkg.sv
package lpr_pkg;
  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_PULSE = 2'd1,
    ST_WAIT  = 2'd2
  } lpr_state_e;
endpackage

// File: rtl/lpr_sync.sv
module lpr_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d[gi]};
      end
      assign q[gi] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/lpr_prescale.sv
module lpr_prescale #(
  parameter int TICK_CYC = 10000,
  localparam int PRE_W   = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic tick
);
  logic [PRE_W-1:0] cnt;
  logic             at_end;

  assign at_end = (cnt == PRE_W'(TICK_CYC - 1));
  assign tick   = en && at_end;

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (en) begin
      if (at_end) cnt <= '0;
      else        cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lpr_ctrl.sv
module lpr_ctrl
  import lpr_pkg::*;
#(
  parameter int HOLD_T0     = 60,
  parameter int HOLD_T1     = 75,
  parameter int HOLD_T2     = 90,
  parameter int HOLD_T3     = 120,
  parameter int PULSE_TICKS = 8,
  parameter int MAIN_W      = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       both_low,
  input  logic [1:0] hold_sel,
  input  logic       tick,
  output logic       pre_clr,
  output logic       pre_en,
  output logic       rst_n_o,
  output logic       rst_o
);
  lpr_state_e        st, st_nxt;
  logic [MAIN_W-1:0] mcnt, mcnt_nxt;
  logic [MAIN_W-1:0] hold_last;

  always_comb begin
    unique case (hold_sel)
      2'd0:    hold_last = MAIN_W'(HOLD_T0 - 1);
      2'd1:    hold_last = MAIN_W'(HOLD_T1 - 1);
      2'd2:    hold_last = MAIN_W'(HOLD_T2 - 1);
      default: hold_last = MAIN_W'(HOLD_T3 - 1);
    endcase
  end

  assign pre_en  = (st == ST_PULSE) || (st == ST_ARMED && both_low);
  assign pre_clr = (st == ST_WAIT)  || (st == ST_ARMED && !both_low);

  always_comb begin
    st_nxt   = st;
    mcnt_nxt = mcnt;
    unique case (st)
      ST_ARMED: begin
        if (!both_low) mcnt_nxt = '0;
        else if (tick) begin
          if (mcnt == hold_last) begin
            st_nxt   = ST_PULSE;
            mcnt_nxt = '0;
          end else begin
            mcnt_nxt = mcnt + 1'b1;
          end
        end
      end
      ST_PULSE: begin
        if (tick) begin
          if (mcnt == MAIN_W'(PULSE_TICKS - 1)) begin
            st_nxt   = ST_WAIT;
            mcnt_nxt = '0;
          end else begin
            mcnt_nxt = mcnt + 1'b1;
          end
        end
      end
      default: begin
        mcnt_nxt = '0;
        if (!both_low) st_nxt = ST_ARMED;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_ARMED;
      mcnt    <= '0;
      rst_n_o <= 1'b1;
      rst_o   <= 1'b0;
    end else begin
      st      <= st_nxt;
      mcnt    <= mcnt_nxt;
      rst_n_o <= (st_nxt != ST_PULSE);
      rst_o   <= (st_nxt == ST_PULSE);
    end
  end
endmodule

// File: rtl/lpr_timer.sv
module lpr_timer #(
  parameter int CLK_HZ        = 200000,
  parameter int TICKS_PER_SEC = 20,
  parameter int HOLD_T0       = 60,
  parameter int HOLD_T1       = 75,
  parameter int HOLD_T2       = 90,
  parameter int HOLD_T3       = 120,
  parameter int PULSE_TICKS   = 8,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       btn_a_n,
  input  logic       btn_b_n,
  input  logic [1:0] hold_sel,
  output logic       rst_n_o,
  output logic       rst_o
);
  localparam int TICK_CYC = CLK_HZ / TICKS_PER_SEC;
  localparam int MAX_A    = (HOLD_T0 > HOLD_T1) ? HOLD_T0 : HOLD_T1;
  localparam int MAX_B    = (HOLD_T2 > HOLD_T3) ? HOLD_T2 : HOLD_T3;
  localparam int MAX_C    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_T    = (MAX_C > PULSE_TICKS) ? MAX_C : PULSE_TICKS;
  localparam int MAIN_W   = $clog2(MAX_T + 1);

  logic [1:0] btn_s;
  logic       both_low;
  logic       tick, pre_clr, pre_en;

  lpr_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({btn_b_n, btn_a_n}), .q(btn_s)
  );

  assign both_low = (btn_s == 2'b00);

  lpr_prescale #(.TICK_CYC(TICK_CYC)) u_pre (
    .clk(clk), .rst(rst), .clr(pre_clr), .en(pre_en), .tick(tick)
  );

  lpr_ctrl #(
    .HOLD_T0(HOLD_T0), .HOLD_T1(HOLD_T1), .HOLD_T2(HOLD_T2), .HOLD_T3(HOLD_T3),
    .PULSE_TICKS(PULSE_TICKS), .MAIN_W(MAIN_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .both_low(both_low), .hold_sel(hold_sel),
    .tick(tick), .pre_clr(pre_clr), .pre_en(pre_en),
    .rst_n_o(rst_n_o), .rst_o(rst_o)
  );
endmodule

// File: rtl/lpr_timer_chk.sv
module lpr_timer_chk #(
  parameter int CLK_HZ        = 200000,
  parameter int TICKS_PER_SEC = 20,
  parameter int PULSE_TICKS   = 8
) (
  input logic clk,
  input logic rst,
  input logic both_low,
  input logic rst_n_o,
  input logic rst_o
);
  localparam int PULSE_CYC = (CLK_HZ / TICKS_PER_SEC) * PULSE_TICKS;

  int low_cnt;
  always_ff @(posedge clk) begin
    if (rst || rst_n_o) low_cnt <= 0;
    else                low_cnt <= low_cnt + 1;
  end

  AST_OUT_COMPL: assert property (@(posedge clk) disable iff (rst)
    rst_o == !rst_n_o); // R9
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (rst_n_o && !rst_o)); // R7
  AST_FALL_NEEDS_BOTH: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_n_o) |-> $past(both_low)); // R2
  AST_PULSE_LEN: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_n_o) |-> (low_cnt == PULSE_CYC)); // R5
  AST_NO_RETRIG: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_n_o) |=> rst_n_o); // R6
endmodule

bind lpr_timer lpr_timer_chk #(
  .CLK_HZ(CLK_HZ), .TICKS_PER_SEC(TICKS_PER_SEC), .PULSE_TICKS(PULSE_TICKS)
) u_chk (
  .clk(clk), .rst(rst), .both_low(both_low), .rst_n_o(rst_n_o), .rst_o(rst_o)
);

// File: tb/tb_lpr_timer.sv
module tb_lpr_timer;
  localparam int CLK_PERIOD = 10;
  localparam int TB_HZ      = 80;
  localparam int TB_TICK    = TB_HZ / 20;
  localparam int PULSE_CYC  = 8 * TB_TICK;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] btn = 2'b11;
  logic [1:0] sel = 2'd0;
  logic       rst_n_o, rst_o;

  int total = 0, bad = 0, cyc = 0;
  int m_st = 0, held = 0, pc = 0;
  logic [1:0] m_s1 = 2'b11, m_s2 = 2'b11;
  int pulses = 0, fall_cyc = 0, width = 0, press_cyc = 0;
  logic prev_n = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpr_timer #(.CLK_HZ(TB_HZ)) dut (
    .clk(clk), .rst(rst), .btn_a_n(btn[0]), .btn_b_n(btn[1]),
    .hold_sel(sel), .rst_n_o(rst_n_o), .rst_o(rst_o)
  );

  function automatic int hold_cyc(input logic [1:0] s);
    case (s)
      2'd0: return 60 * TB_TICK;
      2'd1: return 75 * TB_TICK;
      2'd2: return 90 * TB_TICK;
      default: return 120 * TB_TICK;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference model
  always @(posedge clk) begin
    bit bl;
    cyc++;
    if (rst) begin
      m_s1 = 2'b11; m_s2 = 2'b11; m_st = 0; held = 0; pc = 0;
    end else begin
      bl = (m_s2 == 2'b00);
      m_s2 = m_s1; m_s1 = btn;
      case (m_st)
        0: if (!bl) held = 0;
           else begin
             held++;
             if (held == hold_cyc(sel)) begin m_st = 1; held = 0; pc = 0; end
           end
        1: begin pc++; if (pc == PULSE_CYC) m_st = 2; end
        default: if (!bl) m_st = 0;
      endcase
    end
  end

  // per-cycle compare and pulse monitor
  always @(negedge clk) begin
    check(rst_n_o == (m_st != 1), "R5 model rst_n_o", rst_n_o, m_st != 1);
    check(rst_o == (m_st == 1), "R9 model rst_o", rst_o, m_st == 1);
    if (prev_n && !rst_n_o) begin fall_cyc = cyc; pulses++; end
    if (!prev_n && rst_n_o) width = cyc - fall_cyc;
    prev_n = rst_n_o;
  end

  task automatic drive(input logic [1:0] b, input int n);
    @(negedge clk);
    btn = b;
    if (b == 2'b00) press_cyc = cyc;
    repeat (n - 1) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int p0;
    // R7: reset with buttons held down
    btn = 2'b00;
    repeat (600) @(negedge clk);
    check(rst_n_o == 1 && rst_o == 0, "R7 reset idle", rst_n_o, 1);
    check(pulses == 0, "R7 no pulse in reset", pulses, 0);
    btn = 2'b11;
    @(negedge clk); rst = 1'b0;
    repeat (5) @(negedge clk);

    // R2: only one button
    drive(2'b10, 600); drive(2'b01, 600); drive(2'b11, 5);
    check(pulses == 0, "R2 single button", pulses, 0);

    // R3: release one tick short, then full press
    sel = 2'd0;
    drive(2'b00, hold_cyc(0) - TB_TICK); drive(2'b11, 3);
    check(pulses == 0, "R3 short press", pulses, 0);
    drive(2'b00, hold_cyc(0) + 10);
    check(pulses == 1, "R3 pulse after full press", pulses, 1);
    check(fall_cyc - press_cyc == hold_cyc(0) + 2, "R1 latency sel0", fall_cyc - press_cyc, hold_cyc(0) + 2);
    repeat (PULSE_CYC) @(negedge clk);
    check(width == PULSE_CYC, "R5 width", width, PULSE_CYC);
    drive(2'b11, 5);

    // R4: other select codes
    for (int s = 1; s < 4; s++) begin
      sel = 2'(s);
      p0 = pulses;
      drive(2'b00, hold_cyc(2'(s)) + PULSE_CYC + 20);
      check(pulses == p0 + 1, "R4 one pulse", pulses, p0 + 1);
      check(fall_cyc - press_cyc == hold_cyc(2'(s)) + 2, "R4 latency", fall_cyc - press_cyc, hold_cyc(2'(s)) + 2);
      drive(2'b11, 5);
    end

    // R6: long hold, then re-press
    sel = 2'd0; p0 = pulses;
    drive(2'b00, 3 * hold_cyc(0));
    check(pulses == p0 + 1, "R6 single pulse on long hold", pulses, p0 + 1);
    drive(2'b01, 4);
    drive(2'b00, hold_cyc(0) + 5);
    check(pulses == p0 + 2, "R6 re-press pulse", pulses, p0 + 2);
    repeat (PULSE_CYC) @(negedge clk);

    // R8: release during pulse
    drive(2'b11, 5);
    drive(2'b00, hold_cyc(0) + 6);
    drive(2'b11, PULSE_CYC + 10);
    check(width == PULSE_CYC, "R8 width with release", width, PULSE_CYC);

    // R3: one-cycle glitch clears
    p0 = pulses;
    drive(2'b00, hold_cyc(0) / 2); drive(2'b10, 1);
    drive(2'b00, hold_cyc(0) + 5);
    check(pulses == p0 + 1, "R3 glitch pulse count", pulses, p0 + 1);
    check(fall_cyc - press_cyc == hold_cyc(0) + 2, "R3 glitch restart", fall_cyc - press_cyc, hold_cyc(0) + 2);
    drive(2'b11, PULSE_CYC + 5);

    // R7: reset mid count
    p0 = pulses;
    drive(2'b00, hold_cyc(0) - 20);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(rst_n_o == 1 && rst_o == 0, "R7 idle after reset", rst_n_o, 1);
    repeat (40) @(negedge clk);
    check(pulses == p0, "R7 count cleared by reset", pulses, p0);
    drive(2'b11, 5);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule